// File: doc/BRIEF.md
# Maskable Interrupt Status Register

This block gathers up to 32 single-cycle hardware event pulses into a sticky status register and drives one level-sensitive interrupt line. Each event input bit latches into the status bit of the same index. Software reads the status, clears serviced bits by writing ones to the status address, and can inject bits through a separate set address, which lets driver code exercise its interrupt handler without real hardware events. A mask register chooses which status bits reach the interrupt line. A mask bit of zero lets its status bit through. A mask bit of one blocks it.

Some status positions are tied to fixed sources. Encoder sources sit in the top byte: bit 27 is DMA done, bit 28 is the video input reset, bit 29 is VBI capture, bit 30 is end of stream and bit 31 is capture start. Decoder sources sit lower: bit 18 is the linked-list DMA fault, bit 19 is VBI reinsertion, bit 20 is DMA done, bit 22 is the data request and bit 24 is the audio mode change. The remaining positions have no source, but they still latch when software sets them. The register port is a plain address, write strobe and write data bus with a combinational read data bus. Offset 0x40 holds the status, 0x44 is the set register and 0x48 holds the mask.

Top module: `irq_stat_mask`

## Requirements
- R1: After reset the status reads 0x00000000, the mask reads 0xFFFFFFFF and `irqOut` is 0.
- R2: When `eventsIn[i]` is high in a cycle, status bit i is 1 after that clock edge. Bit i then stays 1 until software clears it. This holds for every i, including the fixed source positions 18, 19, 20, 22, 24 and 27 to 31.
- R3: A write to offset 0x44 sets every status bit whose write-data bit is 1, on the next edge. This applies to positions with no event source as well.
- R4: A write to offset 0x40 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x48 loads the whole mask from the write data, and the new value reads back at offset 0x48.
- R7: `irqOut` is 1 when some status bit is 1 and its mask bit is 0. It follows status and mask changes one clock cycle later, because the output is registered.
- R8: A read at offset 0x40 returns the status and a read at 0x48 returns the mask. A read at 0x44 or at any other offset returns zero. A write to an unmapped offset changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr`, combinational |
| eventsIn | input | 32 | Hardware event pulses, one per status bit |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit address and the offsets 0x40, 0x44 and 0x48. These defaults let the bench reach every status position, both the named sources and the positions with no source. They also put an unmapped offset (0x4C) next to the mapped ones, so the bench can show that a write there does nothing. Directed cases cover these conditions:
- a clear and an event on the same bit in the same cycle;
- a mask that opens or closes while a status bit is already set;
- the one-cycle interrupt latency.

A long run of random addresses, write data and event patterns then compares reads and the interrupt line against the model on every cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    logic clrStatus;   // write-one-to-clear on status
    logic setStatus;   // write-one-to-set through the set register
    logic loadMask;    // full mask load
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_t;

  // Fixed event source bit positions
  localparam int unsigned BIT_ENC_CAP_START = 31;
  localparam int unsigned BIT_ENC_EOS       = 30;
  localparam int unsigned BIT_ENC_VBI_CAP   = 29;
  localparam int unsigned BIT_VIN_RESET     = 28;
  localparam int unsigned BIT_ENC_DMA_DONE  = 27;
  localparam int unsigned BIT_DEC_AUD_MODE  = 24;
  localparam int unsigned BIT_DEC_DATA_REQ  = 22;
  localparam int unsigned BIT_DEC_DMA_DONE  = 20;
  localparam int unsigned BIT_DEC_VBI_INS   = 19;
  localparam int unsigned BIT_DEC_DMA_LLERR = 18;

endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] SET_OFS    = 8'h44,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h48
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);

  always_comb begin
    strobe.clrStatus = wrEn && (regAddr == STATUS_OFS);
    strobe.setStatus = wrEn && (regAddr == SET_OFS);
    strobe.loadMask  = wrEn && (regAddr == MASK_OFS);
  end

  always_comb begin
    if (regAddr == STATUS_OFS)    rdSel = RD_STATUS;
    else if (regAddr == MASK_OFS) rdSel = RD_MASK;
    else                          rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] eventsIn,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam logic [DATA_W-1:0] MASK_RST = {DATA_W{1'b1}};

  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] statusNext;
  logic [DATA_W-1:0] pendVec;

  assign clrVec  = strobe.clrStatus ? wrData : '0;
  assign setVec  = strobe.setStatus ? wrData : '0;
  assign pendVec = statusQ & ~maskQ;

  // Per-bit update: any set source outranks the clear
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      if (eventsIn[i] || setVec[i]) statusNext[i] = 1'b1;
      else if (clrVec[i])           statusNext[i] = 1'b0;
      else                          statusNext[i] = statusQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= MASK_RST;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strobe.loadMask) maskQ <= wrData;
      irqOut  <= |pendVec;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdData = statusQ;
      RD_MASK:   rdData = maskQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] SET_OFS    = 8'h44,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] eventsIn,
  output logic              irqOut
);

  regStrobe_t        strobe;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;

  irq_stat_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .SET_OFS(SET_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .regAddr(regAddr),
    .wrEn(wrEn),
    .strobe(strobe),
    .rdSel(rdSel)
  );

  irq_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .rdSel(rdSel),
    .wrData(wrData),
    .eventsIn(eventsIn),
    .statusQ(statusQ),
    .maskQ(maskQ),
    .rdData(rdData),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] SET_OFS    = 8'h44,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h48
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] eventsIn,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] maskQ,
  input logic              irqOut
);

  assert_event_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (eventsIn != '0) |=> ((statusQ & $past(eventsIn)) == $past(eventsIn)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == STATUS_OFS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  assert_inject_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == SET_OFS) |=> ((statusQ & $past(wrData)) == $past(wrData)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == STATUS_OFS) |=>
      ((statusQ & $past(wrData) & ~$past(eventsIn)) == '0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == MASK_OFS) |=> (maskQ == $past(wrData)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == MASK_OFS) |=> $stable(maskQ));

  assert_irq_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusQ & ~maskQ))));

endmodule

bind irq_stat_mask irq_stat_mask_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .STATUS_OFS(STATUS_OFS), .SET_OFS(SET_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
  .eventsIn(eventsIn), .statusQ(statusQ), .maskQ(maskQ), .irqOut(irqOut)
);

// File: tb/irq_stat_mask_tb.sv
`timescale 1ns/1ps
module irq_stat_mask_tb;

  localparam logic [7:0] A_STAT = 8'h40;
  localparam logic [7:0] A_SET  = 8'h44;
  localparam logic [7:0] A_MASK = 8'h48;
  localparam logic [7:0] A_NONE = 8'h4C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] eventsIn = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int vectors = 0;
  int fails = 0;

  // reference model state
  logic [31:0] stM = '0;
  logic [31:0] mkM = '1;
  logic        irqM = 1'b0;

  always #2 clk = ~clk;

  irq_stat_mask u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .eventsIn(eventsIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a == A_STAT) return stM;
    if (a == A_MASK) return mkM;
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare before the edge, then advance the model
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [31:0] ev, input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    regAddr = a; wrEn = w; wrData = d; eventsIn = ev;
    #1;
    check(rdData, expRead(a), {tag, " read"});
    check({31'b0, irqOut}, {31'b0, irqM}, "R7 irq");
    @(posedge clk);
    nxt = (stM & ~((w && a == A_STAT) ? d : 32'h0)) | ev | ((w && a == A_SET) ? d : 32'h0);
    irqM = |(stM & ~mkM);
    if (w && a == A_MASK) mkM = d;
    stM = nxt;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset values
    step(A_STAT, 0, 0, 0, "R1 status reset");
    step(A_MASK, 0, 0, 0, "R1 mask reset");
    check({31'b0, irqOut}, 32'h0, "R1 irq reset");
    // R2 named source events latch and stick; mask all ones keeps irq low (R7)
    step(A_STAT, 0, 0, 32'hF8000000, "R2 encoder events");
    step(A_STAT, 0, 0, 32'h015C0000, "R2 decoder events");
    step(A_STAT, 0, 0, 0, "R2 sticky");
    step(A_STAT, 0, 0, 0, "R7 masked no irq");
    // R4 clear subset, others stay
    step(A_STAT, 1, 32'h08040000, 0, "R4 partial clear");
    step(A_STAT, 1, 32'hFFFFFFFF, 0, "R4 full clear");
    step(A_STAT, 0, 0, 0, "R4 after clear");
    // R3 inject including reserved bits 25, 0
    step(A_SET, 1, 32'h02000001, 0, "R3 set reads zero R8");
    step(A_STAT, 0, 0, 0, "R3 reserved latch");
    // R5 event and clear collide on bit 25 and bit 31
    step(A_STAT, 1, 32'h82000001, 32'h82000000, "R5 collide");
    step(A_STAT, 0, 0, 0, "R5 set wins");
    // R6/R7 open mask bit 31 -> irq one cycle later
    step(A_MASK, 1, 32'h7FFFFFFF, 0, "R6 mask load");
    step(A_MASK, 0, 0, 0, "R6 mask readback");
    step(A_MASK, 0, 0, 0, "R7 irq high");
    step(A_STAT, 1, 32'h80000000, 0, "R7 clear pending");
    step(A_STAT, 0, 0, 0, "R7 irq falls");
    step(A_MASK, 1, 32'hFFFFFFFF, 0, "R7 close mask");
    // R8 unmapped write ignored, reads zero
    step(A_NONE, 1, 32'h00000000, 0, "R8 unmapped write");
    step(A_NONE, 1, 32'hFFFFFFFF, 0, "R8 unmapped read");
    step(A_STAT, 0, 0, 0, "R8 status intact");
    step(A_MASK, 0, 0, 0, "R8 mask intact");
    // random mix
    void'($urandom(32'h1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [31:0] ev;
      case ($urandom % 4)
        0: a = A_STAT; 1: a = A_SET; 2: a = A_MASK; default: a = A_NONE;
      endcase
      ev = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      step(a, ($urandom % 3) == 0, $urandom & $urandom, ev, "R2-R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule